// File: doc/BRIEF.md
# Variable-Group Carry-Select Adder

A purely combinational adder for two 32-bit operands and a carry input. It produces a 32-bit sum and a carry output. The word is split, from the least significant end, into groups whose sizes grow toward the most significant end. Each group is a ripple of small lookahead cells, and a cell is one or two bits wide.

The lowest group adds directly with the external carry. Every higher group holds two copies of its cell chain. One copy assumes an incoming carry of 0 and the other assumes 1, so both results are ready early. The true carry that leaves the group below then steers a 2:1 multiplexer, which picks the sum bits and the outgoing carry. That picked carry drives the next group's multiplexer.

Group sizes grow because a group's select signal becomes valid at the later of two times, its own chain settling and the previous select settling, plus one multiplexer delay. Larger groups toward the top therefore hide their longer chains behind the select ripple.

The group sizes and the cell width are parameters. Three sizings are intended:
- the default, which uses two-bit cells in groups of 1,1,2,3,4,5 cells;
- single-bit cells in groups of 1,1,1,2,3,4,5,7,8 bits;
- a fixed two-stage split into two 16-bit halves.

Top module: `csa_adder`

## Requirements
- R1: `{carry_out, sum_out}` equals `op_a + op_b + carry_in`, taken as an unsigned 33-bit sum, for every input combination.
- R2: The group sizes are given by the packed parameter `GROUP_CELLS`, which holds one 8-bit field per group with group 0 in bits [7:0]. Elaboration stops with an error unless the sizes, multiplied by the cell width, add up to the operand width. The default is two-bit cells in groups of 1,1,2,3,4,5 cells.
- R3: A two-bit cell computes its carry out as G | (H & cin). Here G = a1·b1 | (a1|b1)·a0·b0 and H = (a1|b1)·(a0|b0). Its two sum bits are correct for all 32 combinations of its inputs.
- R4: The lowest group uses `carry_in` directly. With both operands zero, `carry_in` = 1 gives a sum of 1 and `carry_out` = 0.
- R5: Each higher group yields the correct sum bits and outgoing carry both when the carry entering it is 0 and when it is 1. Its carry-1 result always equals its carry-0 result plus one.
- R6: A carry that enters at bit 0 and propagates through every group reaches `carry_out`. All ones plus zero plus a carry of 1 gives a sum of 0 and `carry_out` = 1; without the carry, the sum is all ones and `carry_out` = 0.
- R7: With single-bit cells in groups of 1,1,1,2,3,4,5,7,8 bits, the adder meets R1.
- R8: With two-bit cells in two groups of 8 cells (two 16-bit halves), the adder meets R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 32 | Sum bits |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
The bench targets the carry entering each group boundary. It feeds vectors in which a run of ones below a chosen bit turns the carry into that bit on or off. A design whose multiplexer select is inverted, or wired to the wrong group, then gives sums that are off by a power of two at that boundary.

A cell whose G or H term is wrong would drop or invent a carry across a two-bit pair. Full-length propagation vectors expose a broken select chain as a missing `carry_out`.

All three sizings run the same vectors plus random operands. A misplaced group offset in any one of them shows up as misaligned sum bits.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
package csa_pkg;
    localparam int unsigned SIZE_FIELD_W = 8;

    typedef struct packed {
        logic gen;
        logic nokill;
    } gh_t;

    function automatic gh_t pair_gh(input logic [1:0] a, input logic [1:0] b);
        gh_t r;
        r.gen    = (a[1] & b[1]) | ((a[1] | b[1]) & a[0] & b[0]);
        r.nokill = (a[1] | b[1]) & (a[0] | b[0]);
        return r;
    endfunction
endpackage

// File: rtl/csa_cell.sv
`timescale 1ns/1ps
module csa_cell #(
    parameter int CELL_W = 2
) (
    input  logic [CELL_W-1:0] a,
    input  logic [CELL_W-1:0] b,
    input  logic              cin,
    output logic [CELL_W-1:0] sum,
    output logic              cout
);
    import csa_pkg::*;

    generate
        if (CELL_W == 1) begin : g_bit
            assign sum  = a ^ b ^ cin;
            assign cout = (a & b) | ((a | b) & cin);
        end else if (CELL_W == 2) begin : g_pair
            gh_t  gh;
            logic c_mid;
            assign gh     = pair_gh(a, b);
            assign c_mid  = (a[0] & b[0]) | ((a[0] | b[0]) & cin);
            assign cout   = gh.gen | (gh.nokill & cin);
            assign sum[0] = a[0] ^ b[0] ^ cin;
            assign sum[1] = a[1] ^ b[1] ^ c_mid;
        end else begin : g_bad_width
            $error("csa_cell: CELL_W must be 1 or 2");
        end
    endgenerate

    logic [CELL_W:0] ref_sum;
    assign ref_sum = {1'b0, a} + {1'b0, b} + {{CELL_W{1'b0}}, cin};

    always_comb begin
        p_cell_carry_r3: assert (cout == ref_sum[CELL_W] && sum == ref_sum[CELL_W-1:0])
            else $error("R3: cell result differs from arithmetic sum");
    end
endmodule

// File: rtl/csa_chain.sv
`timescale 1ns/1ps
module csa_chain #(
    parameter int CELL_W  = 2,
    parameter int N_CELLS = 1
) (
    input  logic [N_CELLS*CELL_W-1:0] a,
    input  logic [N_CELLS*CELL_W-1:0] b,
    input  logic                      cin,
    output logic [N_CELLS*CELL_W-1:0] sum,
    output logic                      cout
);
    logic [N_CELLS:0] c;
    assign c[0] = cin;

    for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
        csa_cell #(.CELL_W(CELL_W)) cell_i (
            .a    (a[k*CELL_W +: CELL_W]),
            .b    (b[k*CELL_W +: CELL_W]),
            .cin  (c[k]),
            .sum  (sum[k*CELL_W +: CELL_W]),
            .cout (c[k+1])
        );
    end

    assign cout = c[N_CELLS];
endmodule

// File: rtl/csa_group.sv
`timescale 1ns/1ps
module csa_group #(
    parameter int CELL_W   = 2,
    parameter int N_CELLS  = 1,
    parameter bit SELECTED = 1'b1
) (
    input  logic [N_CELLS*CELL_W-1:0] a,
    input  logic [N_CELLS*CELL_W-1:0] b,
    input  logic                      cin,
    output logic [N_CELLS*CELL_W-1:0] sum,
    output logic                      cout
);
    localparam int GW = N_CELLS * CELL_W;

    generate
        if (!SELECTED) begin : g_direct
            csa_chain #(.CELL_W(CELL_W), .N_CELLS(N_CELLS)) chain_i (
                .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
            );
        end else begin : g_select
            logic [GW-1:0] sum_c0, sum_c1;
            logic          cout_c0, cout_c1;

            csa_chain #(.CELL_W(CELL_W), .N_CELLS(N_CELLS)) chain_c0_i (
                .a(a), .b(b), .cin(1'b0), .sum(sum_c0), .cout(cout_c0)
            );
            csa_chain #(.CELL_W(CELL_W), .N_CELLS(N_CELLS)) chain_c1_i (
                .a(a), .b(b), .cin(1'b1), .sum(sum_c1), .cout(cout_c1)
            );

            assign sum  = cin ? sum_c1  : sum_c0;
            assign cout = cin ? cout_c1 : cout_c0;

            always_comb begin
                p_pair_step_r5: assert ({cout_c1, sum_c1} == {cout_c0, sum_c0} + (GW+1)'(1))
                    else $error("R5: carry-1 copy is not carry-0 copy plus one");
                p_carry_monotone_r5: assert (!cout_c0 || cout_c1)
                    else $error("R5: carry-0 copy carries while carry-1 copy does not");
            end
        end
    endgenerate
endmodule

// File: rtl/csa_adder.sv
`timescale 1ns/1ps
module csa_adder #(
    parameter int WIDTH    = 32,
    parameter int CELL_W   = 2,
    parameter int N_GROUPS = 6,
    parameter logic [N_GROUPS*8-1:0] GROUP_CELLS =
        {8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd1}
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);
    import csa_pkg::*;

    function automatic int cells_before(input int g);
        int acc;
        acc = 0;
        for (int i = 0; i < g; i++)
            acc += int'(GROUP_CELLS[i*SIZE_FIELD_W +: SIZE_FIELD_W]);
        return acc;
    endfunction

    localparam int TOTAL_BITS = cells_before(N_GROUPS) * CELL_W;

    generate
        if (TOTAL_BITS != WIDTH) begin : g_bad_sizes
            $error("csa_adder: group sizes (R2) do not cover the operand width");
        end
    endgenerate

    logic [N_GROUPS:0] gcarry;
    assign gcarry[0] = carry_in;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        localparam int NC  = int'(GROUP_CELLS[g*SIZE_FIELD_W +: SIZE_FIELD_W]);
        localparam int LSB = cells_before(g) * CELL_W;
        csa_group #(
            .CELL_W  (CELL_W),
            .N_CELLS (NC),
            .SELECTED(g != 0)
        ) grp_i (
            .a    (op_a[LSB +: NC*CELL_W]),
            .b    (op_b[LSB +: NC*CELL_W]),
            .cin  (gcarry[g]),
            .sum  (sum_out[LSB +: NC*CELL_W]),
            .cout (gcarry[g+1])
        );
    end

    assign carry_out = gcarry[N_GROUPS];

    always_comb begin
        p_total_sum_r1: assert ({carry_out, sum_out} ==
                                 {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in})
            else $error("R1: adder output differs from arithmetic sum");
    end
endmodule

// File: tb/csa_adder_tb_top.sv
`timescale 1ns/1ps
module csa_adder_tb_top;
    localparam int W = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0] a = '0, b = '0;
    logic         ci = 1'b0;
    logic [W-1:0] s_def, s_bit, s_half;
    logic         co_def, co_bit, co_half;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    csa_adder dut_i (
        .op_a(a), .op_b(b), .carry_in(ci), .sum_out(s_def), .carry_out(co_def)
    );
    csa_adder #(
        .CELL_W(1), .N_GROUPS(9),
        .GROUP_CELLS({8'd8, 8'd7, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd1, 8'd1})
    ) dut_bit_i (
        .op_a(a), .op_b(b), .carry_in(ci), .sum_out(s_bit), .carry_out(co_bit)
    );
    csa_adder #(
        .CELL_W(2), .N_GROUPS(2), .GROUP_CELLS({8'd8, 8'd8})
    ) dut_half_i (
        .op_a(a), .op_b(b), .carry_in(ci), .sum_out(s_half), .carry_out(co_half)
    );

    // {op_a, op_b, carry_in}
    localparam logic [64:0] VECS [12] = '{
        {32'h0000_0000, 32'h0000_0000, 1'b0},
        {32'h0000_0000, 32'h0000_0000, 1'b1},
        {32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
        {32'hFFFF_FFFF, 32'h0000_0000, 1'b0},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},
        {32'h0000_0003, 32'h0000_0001, 1'b0},
        {32'h0000_0001, 32'h0000_0001, 1'b1},
        {32'h0000_0002, 32'h0000_0002, 1'b0},
        {32'h0000_FFFF, 32'h0000_0001, 1'b0},
        {32'h8000_0000, 32'h8000_0000, 1'b0},
        {32'h5555_5555, 32'hAAAA_AAAA, 1'b1},
        {32'h1234_5678, 32'h9ABC_DEF0, 1'b1}
    };

    task automatic one(input string tag, input logic [W:0] got, input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h cin=%b got=%h exp=%h", tag, a, b, ci, got, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc,
                         input string tag);
        logic [W:0] exp;
        @(negedge clk);
        a = va; b = vb; ci = vc;
        #2;
        exp = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
        one({tag, " R1 default"}, {co_def, s_def}, exp);
        one({tag, " R7 single-bit"}, {co_bit, s_bit}, exp);
        one({tag, " R8 halves"}, {co_half, s_half}, exp);
    endtask

    initial begin
        #1;
        // R4 reset-like state: all-zero inputs
        one("R4 zero inputs", {co_def, s_def}, '0);
        for (int i = 0; i < 12; i++)
            apply(VECS[i][64:33], VECS[i][32:1], VECS[i][0], "table");

        // R4 carry_in alone
        apply('0, '0, 1'b1, "R4");
        one("R4 sum is one", {co_def, s_def}, 33'd1);

        // R6 full propagate
        apply('1, '0, 1'b1, "R6");
        one("R6 wraps to carry", {co_def, s_def}, {1'b1, 32'd0});
        apply('1, '0, 1'b0, "R6");
        one("R6 no carry", {co_def, s_def}, {1'b0, 32'hFFFF_FFFF});

        // R3 every input combination of the lowest two-bit cell
        for (int v = 0; v < 32; v++)
            apply({30'd0, v[4:3]}, {30'd0, v[2:1]}, v[0], "R3 cell");

        // R5 carry of 0 and 1 into every bit position
        for (int k = 1; k < W; k++) begin
            logic [W-1:0] low;
            logic [W-1:0] high;
            low  = (32'd1 << k) - 32'd1;
            high = ~low;
            apply(low, 32'd1, 1'b0, "R5 carry1 into boundary");
            apply(low, 32'd0, 1'b0, "R5 carry0 into boundary");
            apply(low | high, 32'd0, 1'b1, "R5 carry1 through upper");
            apply(high, high, 1'b0, "R5 upper generate");
        end

        // R1/R7/R8 random operands
        for (int i = 0; i < 400; i++)
            apply($urandom, $urandom, 1'($urandom), "random");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule